// File: doc/BRIEF.md
# SMRAM Top-of-Memory Access Router

This block decides where each memory cycle goes when a private system-management region is carved from the highest addresses of physical DRAM. A request brings an address, a cycle kind (read, write or cache write-back), the requester it came from (processor bus, graphics port or I/O hub) and a flag that says whether the processor is in management mode. One clock later the block returns a single decision: DRAM, forward to the I/O hub, or terminate. For a terminated read it also returns all-ones data with an abort flag.

The region is set up by three configuration inputs. The first turns the region on. The second selects its size and so sets its base below the top of DRAM. The third, an extended mode, sends blocked accesses on to the I/O hub instead of terminating them. A combinational output gives the top of memory that the operating system may use. Write-backs from the processor always reach DRAM, so that dirty lines from management code can be flushed outside management mode without losing coherency.

Top module: `smram_router`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, the next cycle shows `rsp_valid`, `rsp_abort` and `rsp_data` at zero.
- R2: Every request with `req_valid` high produces exactly one response with `rsp_valid` high on the next clock, carrying the request address on `rsp_addr`. No response appears without a request.
- R3: An address that is not in an active region goes to DRAM (route 0) when it is below `cfg_dram_size`, and to the I/O hub (route 1) otherwise.
- R4: Size select 1, 2 and 3 give regions of 128 KB, 512 KB and 1 MB. The region runs from `cfg_dram_size` minus that size up to `cfg_dram_size` minus one. Size select 0, or `cfg_rgn_en` low, disables the region.
- R5: A processor-origin request (origin 0) with `req_smm` high that hits the region goes to DRAM.
- R6: A processor-origin read (kind 0) or write (kind 1) with `req_smm` low that hits the region is terminated (route 2) when extended mode is off.
- R7: A processor-origin write-back (kind 2) that hits the region goes to DRAM, whatever `req_smm` holds.
- R8: A request from the graphics port (origin 1) or the I/O hub (origin 2) that hits the region never goes to DRAM. It is terminated when extended mode is off and routed to the I/O hub when it is on, whatever `req_smm` holds.
- R9: With `cfg_ext_en` high, a processor read or write that hits the region with `req_smm` low is routed to the I/O hub.
- R10: A terminated response has `rsp_abort` high. Its `rsp_data` is all ones for a read and zero otherwise. Every response that is not terminated has `rsp_abort` low and `rsp_data` zero.
- R11: `os_top` equals `cfg_dram_size` minus the region size while the region is active, and `cfg_dram_size` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 write-back |
| req_origin | input | 2 | 0 processor, 1 graphics port, 2 I/O hub |
| req_smm | input | 1 | Processor is in management mode |
| cfg_rgn_en | input | 1 | Region enable |
| cfg_size_sel | input | 2 | Region size select (0 off, 1 128 KB, 2 512 KB, 3 1 MB) |
| cfg_ext_en | input | 1 | Extended mode: forward blocked hits to the I/O hub |
| cfg_dram_size | input | ADDR_W | Installed DRAM size in bytes |
| rsp_valid | output | 1 | Decision present this cycle |
| rsp_route | output | 2 | 0 DRAM, 1 I/O hub, 2 terminate |
| rsp_addr | output | ADDR_W | Address of the decided request |
| rsp_abort | output | 1 | Cycle was terminated |
| rsp_data | output | DATA_W | Fill data for a terminated read |
| os_top | output | ADDR_W | Top of memory usable by the operating system |

## Verification
The checker assumes that `cfg_dram_size` is at least as large as the largest region, so that the region base never wraps below zero. It also assumes the configuration inputs hold steady during the cycle in which a request is sampled, because the decision and the checker both read them in that cycle. The stimulus uses one DRAM size well above 1 MB per phase and changes the configuration only between requests. Request kinds and origins stay within the three defined codes. The addresses sit on both sides of every region base and of the DRAM top.

// File: rtl/smr_pkg.sv
package smr_pkg;

   typedef enum logic [1:0] {
      CYC_READ  = 2'd0,
      CYC_WRITE = 2'd1,
      CYC_WBACK = 2'd2,
      CYC_RSVD  = 2'd3
   } cyc_e;

   typedef enum logic [1:0] {
      SRC_CPU  = 2'd0,
      SRC_GFX  = 2'd1,
      SRC_HUB  = 2'd2,
      SRC_RSVD = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      RT_DRAM = 2'd0,
      RT_HUB  = 2'd1,
      RT_TERM = 2'd2,
      RT_NONE = 2'd3
   } route_e;

   typedef struct packed {
      route_e route;
      logic   abort;
      logic   fill;
   } verdict_t;

endpackage

// File: rtl/smr_region_decode.sv
module smr_region_decode
   import smr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SZ1_KB     = 128,
   parameter int SZ2_KB     = 512,
   parameter int SZ3_KB     = 1024,
   parameter bit CLAMP_BASE = 1'b1
) (
   input  logic              cfg_rgn_en,
   input  logic [1:0]        cfg_size_sel,
   input  logic [ADDR_W-1:0] cfg_dram_size,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rgn_active,
   output logic              rgn_hit,
   output logic              below_top,
   output logic [ADDR_W-1:0] os_top
);

   localparam logic [ADDR_W-1:0] SZ1_B = ADDR_W'(SZ1_KB) << 10;
   localparam logic [ADDR_W-1:0] SZ2_B = ADDR_W'(SZ2_KB) << 10;
   localparam logic [ADDR_W-1:0] SZ3_B = ADDR_W'(SZ3_KB) << 10;

   logic [ADDR_W-1:0] rgn_bytes;
   logic [ADDR_W-1:0] rgn_base;
   logic              above_base;

   always_comb begin
      unique case (cfg_size_sel)
         2'd1:    rgn_bytes = SZ1_B;
         2'd2:    rgn_bytes = SZ2_B;
         2'd3:    rgn_bytes = SZ3_B;
         default: rgn_bytes = '0;
      endcase
   end

   assign rgn_active = cfg_rgn_en && (cfg_size_sel != 2'd0);

   generate
      if (CLAMP_BASE) begin : g_clamp
         always_comb begin
            if (cfg_dram_size < rgn_bytes) rgn_base = '0;
            else                           rgn_base = cfg_dram_size - rgn_bytes;
         end
      end else begin : g_wrap
         assign rgn_base = cfg_dram_size - rgn_bytes;
      end
   endgenerate

   assign below_top  = req_addr < cfg_dram_size;
   assign above_base = req_addr >= rgn_base;
   assign rgn_hit    = rgn_active && above_base && below_top;
   assign os_top     = rgn_active ? rgn_base : cfg_dram_size;

endmodule

// File: rtl/smr_route_policy.sv
module smr_route_policy
   import smr_pkg::*;
(
   input  logic       rgn_hit,
   input  logic       below_top,
   input  logic [1:0] req_kind,
   input  logic [1:0] req_origin,
   input  logic       req_smm,
   input  logic       cfg_ext_en,
   output verdict_t   verdict
);

   logic from_cpu;
   logic is_wback;
   logic is_read;
   logic cpu_owned;

   assign from_cpu  = src_e'(req_origin) == SRC_CPU;
   assign is_wback  = cyc_e'(req_kind) == CYC_WBACK;
   assign is_read   = cyc_e'(req_kind) == CYC_READ;
   assign cpu_owned = from_cpu && (is_wback || req_smm);

   always_comb begin
      if (!rgn_hit) begin
         verdict.route = below_top ? RT_DRAM : RT_HUB;
      end else if (cpu_owned) begin
         verdict.route = RT_DRAM;
      end else if (cfg_ext_en) begin
         verdict.route = RT_HUB;
      end else begin
         verdict.route = RT_TERM;
      end
      verdict.abort = verdict.route == RT_TERM;
      verdict.fill  = verdict.abort && is_read;
   end

endmodule

// File: rtl/smr_resp_reg.sv
module smr_resp_reg
   import smr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  verdict_t          verdict,
   output logic              rsp_valid,
   output logic [1:0]        rsp_route,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_abort,
   output logic [DATA_W-1:0] rsp_data
);

   logic fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_route <= 2'd0;
         rsp_addr  <= '0;
         rsp_abort <= 1'b0;
         fill_q    <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_route <= verdict.route;
            rsp_addr  <= req_addr;
            rsp_abort <= verdict.abort;
            fill_q    <= verdict.fill;
         end
      end
   end

   assign rsp_data = fill_q ? '1 : '0;

endmodule

// File: rtl/smram_router.sv
module smram_router
   import smr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int SZ1_KB     = 128,
   parameter int SZ2_KB     = 512,
   parameter int SZ3_KB     = 1024,
   parameter bit CLAMP_BASE = 1'b1,
   parameter bit REG_OS_TOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_origin,
   input  logic              req_smm,
   input  logic              cfg_rgn_en,
   input  logic [1:0]        cfg_size_sel,
   input  logic              cfg_ext_en,
   input  logic [ADDR_W-1:0] cfg_dram_size,
   output logic              rsp_valid,
   output logic [1:0]        rsp_route,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_abort,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] os_top
);

   localparam int MAX_KB = 1024;

   generate
      if (ADDR_W < 21 || ADDR_W > 64) begin : g_bad_addr_w
         $error("smram_router: ADDR_W must lie in 21..64");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("smram_router: DATA_W must be a whole number of bytes");
      end
      if (SZ1_KB <= 0 || SZ1_KB >= SZ2_KB || SZ2_KB >= SZ3_KB) begin : g_bad_order
         $error("smram_router: region sizes must be positive and ascending");
      end
      if (SZ3_KB > MAX_KB) begin : g_bad_max
         $error("smram_router: largest region may not exceed 1 MB");
      end
   endgenerate

   logic              rgn_active;
   logic              rgn_hit;
   logic              below_top;
   logic [ADDR_W-1:0] os_top_c;
   verdict_t          verdict;

   smr_region_decode #(
      .ADDR_W     (ADDR_W),
      .SZ1_KB     (SZ1_KB),
      .SZ2_KB     (SZ2_KB),
      .SZ3_KB     (SZ3_KB),
      .CLAMP_BASE (CLAMP_BASE)
   ) u_decode (
      .cfg_rgn_en    (cfg_rgn_en),
      .cfg_size_sel  (cfg_size_sel),
      .cfg_dram_size (cfg_dram_size),
      .req_addr      (req_addr),
      .rgn_active    (rgn_active),
      .rgn_hit       (rgn_hit),
      .below_top     (below_top),
      .os_top        (os_top_c)
   );

   smr_route_policy u_policy (
      .rgn_hit    (rgn_hit),
      .below_top  (below_top),
      .req_kind   (req_kind),
      .req_origin (req_origin),
      .req_smm    (req_smm),
      .cfg_ext_en (cfg_ext_en),
      .verdict    (verdict)
   );

   smr_resp_reg #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .verdict   (verdict),
      .rsp_valid (rsp_valid),
      .rsp_route (rsp_route),
      .rsp_addr  (rsp_addr),
      .rsp_abort (rsp_abort),
      .rsp_data  (rsp_data)
   );

   generate
      if (REG_OS_TOP) begin : g_os_top_reg
         logic [ADDR_W-1:0] os_top_q;
         always_ff @(posedge clk) begin
            if (!rst_n) os_top_q <= '0;
            else        os_top_q <= os_top_c;
         end
         assign os_top = os_top_q;
      end else begin : g_os_top_comb
         assign os_top = os_top_c;
      end
   endgenerate

   logic unused_active;
   assign unused_active = rgn_active;

endmodule

// File: rtl/smram_router_chk.sv
module smram_router_chk
   import smr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SZ1_KB = 128,
   parameter int SZ2_KB = 512,
   parameter int SZ3_KB = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_kind,
   input logic [1:0]        req_origin,
   input logic              req_smm,
   input logic              cfg_rgn_en,
   input logic [1:0]        cfg_size_sel,
   input logic [ADDR_W-1:0] cfg_dram_size,
   input logic              rsp_valid,
   input logic [1:0]        rsp_route,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              rsp_abort,
   input logic [DATA_W-1:0] rsp_data,
   input logic [ADDR_W-1:0] os_top
);

   logic [ADDR_W-1:0] span;
   logic              in_rgn;

   always_comb begin
      case (cfg_size_sel)
         2'd1:    span = ADDR_W'(SZ1_KB) * ADDR_W'(1024);
         2'd2:    span = ADDR_W'(SZ2_KB) * ADDR_W'(1024);
         2'd3:    span = ADDR_W'(SZ3_KB) * ADDR_W'(1024);
         default: span = '0;
      endcase
   end

   assign in_rgn = cfg_rgn_en && (span != '0) && (req_addr < cfg_dram_size) &&
                   (req_addr + span >= cfg_dram_size);

   property p_reset_idle;
      @(posedge clk) !rst_n |=> (!rsp_valid && !rsp_abort && rsp_data == '0);
   endproperty
   AST_RESET_IDLE: assert property (p_reset_idle); // R1

   AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2

   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2

   AST_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_addr == $past(req_addr)); // R2

   AST_SMM_CPU_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_origin == 2'd0 && req_smm && req_addr < cfg_dram_size)
      |=> rsp_route == 2'd0); // R5

   AST_WBACK_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_origin == 2'd0 && req_kind == 2'd2 && req_addr < cfg_dram_size)
      |=> rsp_route == 2'd0); // R7

   AST_FOREIGN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_origin != 2'd0 && in_rgn) |=> rsp_route != 2'd0); // R8

   AST_TERM_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_route == 2'd2) |-> rsp_abort); // R10

   AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_route != 2'd2) |-> (!rsp_abort && rsp_data == '0)); // R10

   AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_route != 2'd3); // R3

   AST_OS_TOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dram_size >= (ADDR_W'(SZ3_KB) * ADDR_W'(1024)) && $stable(cfg_dram_size))
      |-> (os_top <= cfg_dram_size && os_top + ADDR_W'(SZ3_KB) * ADDR_W'(1024) >= cfg_dram_size)); // R11

endmodule

bind smram_router smram_router_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .SZ1_KB (SZ1_KB),
   .SZ2_KB (SZ2_KB),
   .SZ3_KB (SZ3_KB)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_addr      (req_addr),
   .req_kind      (req_kind),
   .req_origin    (req_origin),
   .req_smm       (req_smm),
   .cfg_rgn_en    (cfg_rgn_en),
   .cfg_size_sel  (cfg_size_sel),
   .cfg_dram_size (cfg_dram_size),
   .rsp_valid     (rsp_valid),
   .rsp_route     (rsp_route),
   .rsp_addr      (rsp_addr),
   .rsp_abort     (rsp_abort),
   .rsp_data      (rsp_data),
   .os_top        (os_top)
);

// File: tb/smram_router_tb.sv
module smram_router_tb;

   localparam int AW = 32;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_kind = 2'd0;
   logic [1:0]    req_origin = 2'd0;
   logic          req_smm = 1'b0;
   logic          cfg_rgn_en = 1'b0;
   logic [1:0]    cfg_size_sel = 2'd0;
   logic          cfg_ext_en = 1'b0;
   logic [AW-1:0] cfg_dram_size = 32'h0800_0000;
   logic          rsp_valid;
   logic [1:0]    rsp_route;
   logic [AW-1:0] rsp_addr;
   logic          rsp_abort;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] os_top;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [1:0]    route;
      logic          abort;
      logic [DW-1:0] data;
      logic [AW-1:0] addr;
      string         tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   smram_router u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_addr      (req_addr),
      .req_kind      (req_kind),
      .req_origin    (req_origin),
      .req_smm       (req_smm),
      .cfg_rgn_en    (cfg_rgn_en),
      .cfg_size_sel  (cfg_size_sel),
      .cfg_ext_en    (cfg_ext_en),
      .cfg_dram_size (cfg_dram_size),
      .rsp_valid     (rsp_valid),
      .rsp_route     (rsp_route),
      .rsp_addr      (rsp_addr),
      .rsp_abort     (rsp_abort),
      .rsp_data      (rsp_data),
      .os_top        (os_top)
   );

   function automatic logic [AW-1:0] span_of(input logic [1:0] sel);
      case (sel)
         2'd1:    return 32'h0002_0000;
         2'd2:    return 32'h0008_0000;
         2'd3:    return 32'h0010_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [AW-1:0] exp_top();
      if (cfg_rgn_en && cfg_size_sel != 2'd0) return cfg_dram_size - span_of(cfg_size_sel);
      return cfg_dram_size;
   endfunction

   function automatic exp_t model(input logic [AW-1:0] a, input logic [1:0] k,
                                  input logic [1:0] o, input logic s, input string tag);
      exp_t e;
      logic hit;
      hit = cfg_rgn_en && cfg_size_sel != 2'd0 && a < cfg_dram_size &&
            a >= cfg_dram_size - span_of(cfg_size_sel);
      if (!hit)                            e.route = (a < cfg_dram_size) ? 2'd0 : 2'd1;
      else if (o == 2'd0 && (k == 2'd2 || s)) e.route = 2'd0;
      else if (cfg_ext_en)                 e.route = 2'd1;
      else                                 e.route = 2'd2;
      e.abort = e.route == 2'd2;
      e.data  = (e.abort && k == 2'd0) ? '1 : '0;
      e.addr  = a;
      e.tag   = tag;
      return e;
   endfunction

   function automatic void fail_line(input string msg);
      n_fails++;
      $display("FAIL %s", msg);
   endfunction

   task automatic send(input logic [AW-1:0] a, input logic [1:0] k, input logic [1:0] o,
                       input logic s, input string tag);
      @(negedge clk);
      req_valid  = 1'b1;
      req_addr   = a;
      req_kind   = k;
      req_origin = o;
      req_smm    = s;
      sb.push_back(model(a, k, o, s, tag));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   task automatic set_cfg(input logic en, input logic [1:0] sel, input logic ext,
                          input logic [AW-1:0] dram);
      idle(2);
      cfg_rgn_en    = en;
      cfg_size_sel  = sel;
      cfg_ext_en    = ext;
      cfg_dram_size = dram;
      #1;
      n_checks++;
      if (os_top !== exp_top())
         fail_line($sformatf("R11 os_top actual %h expected %h", os_top, exp_top()));
   endtask

   // monitor: pops the scoreboard as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_checks++;
         if (sb.size() == 0) begin
            fail_line($sformatf("R2 unexpected response addr actual %h expected none", rsp_addr));
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_route !== e.route || rsp_abort !== e.abort ||
                rsp_data !== e.data || rsp_addr !== e.addr)
               fail_line($sformatf("%s route/abort/data/addr actual %0d/%0b/%h/%h expected %0d/%0b/%h/%h",
                  e.tag, rsp_route, rsp_abort, rsp_data, rsp_addr,
                  e.route, e.abort, e.data, e.addr));
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         fail_line("watchdog expired actual running expected finished");
         finish_run();
      end
   end

   localparam logic [AW-1:0] D0 = 32'h0800_0000;

   initial begin
      repeat (3) @(negedge clk);
      n_checks++;  // R1 reset state
      if (rsp_valid !== 1'b0 || rsp_abort !== 1'b0 || rsp_data !== '0)
         fail_line($sformatf("R1 valid/abort/data actual %b/%b/%h expected 0/0/0",
                   rsp_valid, rsp_abort, rsp_data));
      rst_n = 1'b1;

      // region disabled by size 0
      set_cfg(1'b1, 2'd0, 1'b0, D0);
      send(D0 - 4, 2'd0, 2'd0, 1'b0, "R4 sel0 top word");
      send(D0, 2'd0, 2'd0, 1'b0, "R3 at dram top");
      send(32'h0000_1000, 2'd1, 2'd1, 1'b0, "R3 low gfx write");

      // region disabled by enable
      set_cfg(1'b0, 2'd3, 1'b0, D0);
      send(D0 - 16, 2'd0, 2'd0, 1'b0, "R4 enable low");

      // 128 KB region, terminate mode
      set_cfg(1'b1, 2'd1, 1'b0, D0);
      send(32'h07FD_FFFC, 2'd0, 2'd0, 1'b0, "R3 below base");
      send(32'h07FE_0000, 2'd0, 2'd0, 1'b0, "R6 read at base");
      send(D0 - 4, 2'd1, 2'd0, 1'b0, "R10 terminated write");
      send(32'h07FE_0000, 2'd0, 2'd0, 1'b1, "R5 smm read");
      send(32'h07FF_0000, 2'd2, 2'd0, 1'b0, "R7 wback non-smm");
      send(32'h07FE_0040, 2'd0, 2'd1, 1'b0, "R8 gfx read");
      send(32'h07FE_0080, 2'd1, 2'd2, 1'b1, "R8 hub write smm flag");
      send(32'h07FE_00C0, 2'd2, 2'd2, 1'b0, "R8 hub wback");
      send(D0 + 32'h100, 2'd0, 2'd0, 1'b0, "R3 above dram");

      // 512 KB region
      set_cfg(1'b1, 2'd2, 1'b0, D0);
      send(32'h07F8_0000, 2'd0, 2'd0, 1'b0, "R4 512K base");
      send(32'h07F7_FFFC, 2'd0, 2'd0, 1'b0, "R4 512K below");

      // 1 MB region, extended mode
      set_cfg(1'b1, 2'd3, 1'b1, D0);
      send(32'h07F0_0000, 2'd0, 2'd0, 1'b0, "R9 ext read");
      send(32'h07F4_0000, 2'd1, 2'd0, 1'b0, "R9 ext write");
      send(32'h07F0_0100, 2'd1, 2'd1, 1'b0, "R8 ext gfx");
      send(32'h07FF_FFF0, 2'd0, 2'd0, 1'b1, "R5 ext smm");
      send(32'h07F8_0000, 2'd2, 2'd0, 1'b0, "R7 ext wback");
      send(32'h07EF_FFFC, 2'd0, 2'd0, 1'b0, "R4 1M below");

      // other dram size
      set_cfg(1'b1, 2'd3, 1'b0, 32'h1000_0000);
      send(32'h0FF0_0000, 2'd0, 2'd0, 1'b0, "R6 large dram");
      send(32'h0FEF_FFFC, 2'd0, 2'd0, 1'b0, "R3 large dram below");

      idle(4);
      n_checks++;  // R2 every request answered
      if (sb.size() != 0)
         fail_line($sformatf("R2 pending responses actual %0d expected 0", sb.size()));
      done = 1'b1;
      finish_run();
   end

endmodule